// File: doc/BRIEF.md
# Pointer-Plus-Offset Memory Instruction Executor

This block is the execute stage for three data-memory instructions of a small 8-bit accumulator machine. The operand address of each instruction is the sum of a 12-bit pointer register and an 8-bit literal offset carried in the instruction word. The three operations are:

- add the accumulator W to the addressed byte, with the sum going either to W or back to memory;
- set one selected bit of the addressed byte;
- overwrite the addressed byte with all ones.

A one-cycle start pulse hands the unit a 16-bit instruction word. The unit then steps through four fixed phases: decode, operand read, processing, and write-back. It drives a synchronous single-port byte memory and reports completion with a one-cycle done pulse.

The unit owns three registers: the W accumulator, the pointer and a 5-bit status register. W and the pointer can be loaded while the unit is idle. An offset that is out of range, or a word the unit does not recognise, is refused. A refused word raises an illegal flag together with done and changes nothing.

Top module: `ofs_exec_unit`

## Requirements
- R1: After synchronous reset, W, the pointer and the status register are zero, and busy, done, illegal and mem_we are low.
- R2: The unit recognises three instruction encodings; the literal k is bits 7:0 and is legal only in the range 0..95.
  - Add: bits 15:10 = 001001 and bit 8 = 0.
  - Bit set: bits 15:12 = 1000 and bit 8 = 0.
  - Fill: bits 15:8 = 0x68.
  - Any other word, or k above 95, raises illegal together with done, one cycle after the Q1 phase.
- R3: The operand address is pointer + k, taken modulo 4096.
- R4: For the add, bit 9 selects the destination: 0 writes the 8-bit sum to W and leaves memory unchanged; 1 writes the sum to the addressed byte and leaves W unchanged.
- R5: The add loads the status register as follows:
  - bit 0: carry out of bit 7;
  - bit 1: carry out of bit 3;
  - bit 2: the 8-bit sum is zero;
  - bit 3: both operands have the same sign and the sum's sign differs;
  - bit 4: bit 7 of the sum.
- R6: The bit-set instruction sets bit number instr[11:9] of the addressed byte, keeps its other bits, and leaves the status register unchanged.
- R7: The fill instruction writes 0xFF to the addressed byte and leaves the status register unchanged.
- R8: A refused instruction changes no register, no status bit and no memory byte.
- R9: Timing of one instruction:
  - A start seen while idle begins the phases Q1, Q2, Q3 and Q4, one clock each.
  - A legal instruction pulses done for one cycle immediately after Q4, with its result already visible.
  - mem_we is high only during Q4.
- R10: A start presented while the unit is busy is ignored.
- R11: While the unit is idle, w_load and ptr_load write W and the pointer. A load presented in the same cycle as an accepted start is applied before the instruction uses that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `instr` (taken only when idle) |
| instr | input | 16 | Instruction word |
| w_load | input | 1 | Load W from `w_din` (taken only when idle) |
| w_din | input | 8 | New W value |
| ptr_load | input | 1 | Load pointer from `ptr_din` (taken only when idle) |
| ptr_din | input | 12 | New pointer value |
| mem_addr | output | 12 | Data memory address (registered) |
| mem_we | output | 1 | Data memory write enable (registered) |
| mem_wdata | output | 8 | Data memory write data (registered) |
| mem_rdata | input | 8 | Data memory read data, one cycle after the address |
| w_out | output | 8 | Current W |
| ptr_out | output | 12 | Current pointer |
| status_out | output | 5 | Status flags {N, OV, Z, DC, C} |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse, with done, for a refused instruction |

## Verification
Two collisions are provoked on purpose.

The first is a register load that lands in the same cycle as an accepted start. The bench raises w_load together with start and predicts the add's result from the newly loaded W rather than the old one.

The second is a start that arrives while an add is still in its Q2 phase. That stray start carries a fill aimed at a second address. The bench judges it ignored on three counts: only one done is seen, the second byte keeps its old value, and the add's result and latency match the model.

// File: rtl/ofs_exec_pkg.sv
package ofs_exec_pkg;
  localparam int IW = 16;
  localparam int FW = 5;

  typedef enum logic [2:0] {PH_IDLE, PH_Q1, PH_Q2, PH_Q3, PH_Q4} phase_t;
  typedef enum logic [1:0] {OP_NONE, OP_ADD, OP_BSET, OP_FILL} op_t;

  // status layout: bit4 N, bit3 OV, bit2 Z, bit1 DC, bit0 C
  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;
endpackage

// File: rtl/ofs_exec_decode.sv
module ofs_exec_decode
  import ofs_exec_pkg::*;
#(
  parameter int KW   = 8,
  parameter int KMAX = 95,
  parameter int BW   = 3
) (
  input  logic [IW-1:0] ir,
  output op_t           op,
  output logic          dst_mem,
  output logic [BW-1:0] bsel,
  output logic [KW-1:0] k,
  output logic          legal
);
  always_comb begin
    op = OP_NONE;
    if (ir[15:10] == 6'b001001 && !ir[8])
      op = OP_ADD;
    else if (ir[15:12] == 4'b1000 && !ir[8])
      op = OP_BSET;
    else if (ir[15:8] == 8'h68)
      op = OP_FILL;
  end

  assign dst_mem = ir[9];
  assign bsel    = ir[9 +: BW];
  assign k       = ir[KW-1:0];
  assign legal   = (op != OP_NONE) && (k <= KW'(KMAX));
endmodule

// File: rtl/ofs_exec_agu.sv
module ofs_exec_agu #(
  parameter int AW = 12,
  parameter int KW = 8
) (
  input  logic [AW-1:0] ptr,
  input  logic [KW-1:0] k,
  output logic [AW-1:0] ea
);
  // natural wrap at 2**AW
  assign ea = ptr + {{(AW-KW){1'b0}}, k};
endmodule

// File: rtl/ofs_exec_alu.sv
module ofs_exec_alu
  import ofs_exec_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  op_t           op,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] rd,
  input  logic [BW-1:0] bsel,
  output logic [DW-1:0] res,
  output flags_t        fl
);
  localparam int HALF = DW / 2;

  logic [DW:0]     sum;
  logic [HALF:0]   lo;
  logic [DW-1:0]   mask;

  assign sum  = {1'b0, w} + {1'b0, rd};
  assign lo   = {1'b0, w[HALF-1:0]} + {1'b0, rd[HALF-1:0]};
  assign mask = {{(DW-1){1'b0}}, 1'b1} << bsel;

  always_comb begin
    case (op)
      OP_ADD:  res = sum[DW-1:0];
      OP_BSET: res = rd | mask;
      OP_FILL: res = '1;
      default: res = rd;
    endcase
  end

  assign fl.c  = sum[DW];
  assign fl.dc = lo[HALF];
  assign fl.z  = (sum[DW-1:0] == '0);
  assign fl.n  = sum[DW-1];
  assign fl.ov = (w[DW-1] == rd[DW-1]) && (sum[DW-1] != w[DW-1]);
endmodule

// File: rtl/ofs_exec_unit.sv
module ofs_exec_unit
  import ofs_exec_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 12,
  parameter int KW   = 8,
  parameter int KMAX = 95
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] instr,
  input  logic          w_load,
  input  logic [DW-1:0] w_din,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_din,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] w_out,
  output logic [AW-1:0] ptr_out,
  output logic [FW-1:0] status_out,
  output logic          busy,
  output logic          done,
  output logic          illegal
);
  localparam int BW = $clog2(DW);

  phase_t        phase;
  logic [IW-1:0] ir;
  logic [DW-1:0] w_q, res_q, wd_q, alu_res;
  logic [AW-1:0] ptr_q, addr_q, ea;
  flags_t        st_q, fl_q, alu_fl;
  logic          done_q, ill_q, we_q;

  op_t           op;
  logic          dst_mem, legal;
  logic [BW-1:0] bsel;
  logic [KW-1:0] k;

  ofs_exec_decode #(.KW(KW), .KMAX(KMAX), .BW(BW)) u_dec (
    .ir(ir), .op(op), .dst_mem(dst_mem), .bsel(bsel), .k(k), .legal(legal)
  );

  ofs_exec_agu #(.AW(AW), .KW(KW)) u_agu (
    .ptr(ptr_q), .k(k), .ea(ea)
  );

  ofs_exec_alu #(.DW(DW), .BW(BW)) u_alu (
    .op(op), .w(w_q), .rd(mem_rdata), .bsel(bsel), .res(alu_res), .fl(alu_fl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      ir     <= '0;
      w_q    <= '0;
      ptr_q  <= '0;
      st_q   <= '0;
      fl_q   <= '0;
      res_q  <= '0;
      wd_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      we_q   <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (w_load)   w_q   <= w_din;
          if (ptr_load) ptr_q <= ptr_din;
          if (start) begin
            ir    <= instr;
            phase <= PH_Q1;
          end
        end
        PH_Q1: begin
          if (!legal) begin
            ill_q  <= 1'b1;
            done_q <= 1'b1;
            phase  <= PH_IDLE;
          end else begin
            addr_q <= ea;
            phase  <= PH_Q2;
          end
        end
        PH_Q2: phase <= PH_Q3;
        PH_Q3: begin
          res_q <= alu_res;
          fl_q  <= alu_fl;
          if (op != OP_ADD || dst_mem) begin
            we_q <= 1'b1;
            wd_q <= alu_res;
          end
          phase <= PH_Q4;
        end
        PH_Q4: begin
          if (op == OP_ADD) begin
            st_q <= fl_q;
            if (!dst_mem) w_q <= res_q;
          end
          done_q <= 1'b1;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign mem_addr   = addr_q;
  assign mem_we     = we_q;
  assign mem_wdata  = wd_q;
  assign w_out      = w_q;
  assign ptr_out    = ptr_q;
  assign status_out = st_q;
  assign busy       = (phase != PH_IDLE);
  assign done       = done_q;
  assign illegal    = ill_q;
endmodule

// File: rtl/ofs_exec_chk.sv
module ofs_exec_chk #(
  parameter int DW = 8,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          illegal,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] w_out,
  input logic [4:0]    status_out
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_we_then_done_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> done);

  p_start_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_illegal_with_done_r2: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);

  p_illegal_no_effect_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(w_out) && $stable(status_out) && !mem_we));

  p_write_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($stable(mem_addr) && busy));
endmodule

bind ofs_exec_unit ofs_exec_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .illegal(illegal), .mem_we(mem_we), .mem_addr(mem_addr),
  .w_out(w_out), .status_out(status_out)
);

// File: tb/ofs_exec_unit_bench.sv
module ofs_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        w_load = 1'b0;
  logic [7:0]  w_din = '0;
  logic        ptr_load = 1'b0;
  logic [11:0] ptr_din = '0;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  w_out;
  logic [11:0] ptr_out;
  logic [4:0]  status_out;
  logic        busy, done, illegal;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    string       req;
    logic [7:0]  w;
    logic [4:0]  st;
    logic        ill;
    logic [11:0] addr;
    logic [7:0]  mval;
  } exp_t;

  exp_t sbq[$];
  logic [7:0] mem [0:4095];
  logic [7:0]  w_m = '0;
  logic [11:0] ptr_m = '0;
  logic [4:0]  st_m = '0;

  always #10 clk = ~clk;

  ofs_exec_unit u_ofs_exec_unit (
    .clk(clk), .rst(rst), .start(start), .instr(instr),
    .w_load(w_load), .w_din(w_din), .ptr_load(ptr_load), .ptr_din(ptr_din),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .w_out(w_out), .ptr_out(ptr_out),
    .status_out(status_out), .busy(busy), .done(done), .illegal(illegal)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(illegal == e.ill, e.req, "illegal flag", int'(illegal), int'(e.ill));
        chk(w_out == e.w, e.req, "W", int'(w_out), int'(e.w));
        chk(status_out == e.st, e.req, "status", int'(status_out), int'(e.st));
        chk(mem[e.addr] == e.mval, e.req, "memory byte",
            int'(mem[e.addr]), int'(e.mval));
      end
    end
  end

  task automatic load_w(input logic [7:0] v);
    @(negedge clk); w_load = 1'b1; w_din = v;
    @(negedge clk); w_load = 1'b0;
    w_m = v;
  endtask

  task automatic load_ptr(input logic [11:0] v);
    @(negedge clk); ptr_load = 1'b1; ptr_din = v;
    @(negedge clk); ptr_load = 1'b0;
    ptr_m = v;
  endtask

  // driver: predicts, pushes, issues, waits
  task automatic exec(input logic [15:0] ins, input string req,
                      input logic [15:0] intruder, input bit wl,
                      input logic [7:0] wv);
    exp_t e;
    logic [11:0] ea;
    logic [7:0]  kk, m, r;
    logic [8:0]  s;
    logic [4:0]  lo;
    int lat;
    if (wl) w_m = wv;
    kk = ins[7:0];
    ea = ptr_m + {4'h0, kk};
    m  = mem[ea];
    e.req = req; e.ill = 1'b0; e.addr = ea; e.mval = m; e.w = w_m; e.st = st_m;
    if (kk > 8'd95) begin
      e.ill = 1'b1;
    end else if (ins[15:10] == 6'b001001 && !ins[8]) begin
      s  = {1'b0, w_m} + {1'b0, m};
      lo = {1'b0, w_m[3:0]} + {1'b0, m[3:0]};
      r  = s[7:0];
      if (ins[9]) e.mval = r; else e.w = r;
      e.st = {r[7], (w_m[7] == m[7]) && (r[7] != w_m[7]), r == 8'h00, lo[4], s[8]};
    end else if (ins[15:12] == 4'b1000 && !ins[8]) begin
      e.mval = m | (8'h01 << ins[11:9]);
    end else if (ins[15:8] == 8'h68) begin
      e.mval = 8'hFF;
    end else begin
      e.ill = 1'b1;
    end
    sbq.push_back(e);
    @(negedge clk);
    start = 1'b1; instr = ins;
    if (wl) begin w_load = 1'b1; w_din = wv; end
    @(negedge clk);
    start = 1'b0; w_load = 1'b0;
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
      if (lat == 2 && intruder != 16'h0) begin
        start = 1'b1; instr = intruder;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(lat == (e.ill ? 2 : 5), "R9", "done latency", lat, e.ill ? 2 : 5);
    w_m  = e.w;
    st_m = e.st;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(w_out == 8'h00, "R1", "W after reset", int'(w_out), 0);
    chk(ptr_out == 12'h000, "R1", "pointer after reset", int'(ptr_out), 0);
    chk(status_out == 5'h00, "R1", "status after reset", int'(status_out), 0);
    chk({busy, done, illegal, mem_we} == 4'b0, "R1", "control after reset",
        int'({busy, done, illegal, mem_we}), 0);

    load_ptr(12'hA00);
    chk(ptr_out == 12'hA00, "R11", "pointer load", int'(ptr_out), 'hA00);
    load_w(8'h17);
    chk(w_out == 8'h17, "R11", "W load", int'(w_out), 'h17);

    mem[12'hA2C] = 8'h20;
    exec(16'h242C, "R4 add to W", 16'h0, 1'b0, 8'h0);
    mem[12'hA30] = 8'h30;
    exec(16'h2630, "R4 add to memory", 16'h0, 1'b0, 8'h0);

    load_w(8'h7F); mem[12'hA01] = 8'h01;
    exec(16'h2601, "R5 signed overflow", 16'h0, 1'b0, 8'h0);
    load_w(8'hFF); mem[12'hA02] = 8'h01;
    exec(16'h2402, "R5 carry and zero", 16'h0, 1'b0, 8'h0);

    mem[12'hA0A] = 8'h55;
    exec(16'h8E0A, "R6 bit set", 16'h0, 1'b0, 8'h0);
    mem[12'hA2C] = 8'h00;
    exec(16'h682C, "R7 fill", 16'h0, 1'b0, 8'h0);

    mem[12'hA60] = 8'h5A;
    exec(16'h6860, "R2 offset 96 refused", 16'h0, 1'b0, 8'h0);
    exec(16'h685F, "R2 offset 95 accepted", 16'h0, 1'b0, 8'h0);
    mem[12'hA0A] = 8'h3C;
    exec(16'hF00A, "R8 unknown opcode", 16'h0, 1'b0, 8'h0);
    exec(16'h250A, "R8 add with bit8 set", 16'h0, 1'b0, 8'h0);

    load_ptr(12'hFF0); mem[12'h04F] = 8'h03;
    exec(16'h8A5F, "R3 address wrap", 16'h0, 1'b0, 8'h0);

    load_ptr(12'hA00); load_w(8'h01);
    mem[12'hA40] = 8'h11; mem[12'hA41] = 8'h00;
    exec(16'h2640, "R10 start while busy", 16'h6841, 1'b0, 8'h0);
    repeat (8) @(negedge clk);
    chk(mem[12'hA41] == 8'h00, "R10", "stray fill target", int'(mem[12'hA41]), 0);

    mem[12'hA42] = 8'h10;
    exec(16'h2442, "R11 load with start", 16'h0, 1'b1, 8'h05);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R9", "scoreboard drained", sbq.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule